// File: doc/BRIEF.md
# Presettable Cascadable BCD Decade Counter

This block is a single decimal digit held as a 4-bit binary-coded value. On each rising clock edge it clears, loads a preset value, steps to the next decimal digit, or keeps its value. After 9 it returns to 0. Two active-high count enables must both be high for the digit to step. Only one of them, the chain enable, also qualifies the carry output. A row of these stages therefore forms a synchronous multi-digit decimal counter: each stage's carry feeds the chain enable of the next stage, and a shared side enable starts or stops the whole row.

The clear input is active low. The elaboration parameter `ASYNC_CLR` sets how it acts. When set to 1, the clear empties the digit at once, with no clock. When set to 0, the clear acts on the next rising edge and takes precedence over loading and counting. The load input is active low and takes precedence over counting. While counting, the six codes above 9 that a preset can introduce return to the decimal range within two steps. The carry output never fires on one of these codes.

Top module: `bcd_decade_stage`

## Requirements
- R1: With clear and load inactive (both high) and both count enables high, each rising edge moves the digit one step through 0,1,...,9. The step after 9 is 0.
- R2: With `ASYNC_CLR`=1, a low on `clr_n` forces `digit` to 0 with no clock edge, whatever the other inputs are.
- R3: With `ASYNC_CLR`=0, a low on `clr_n` leaves `digit` unchanged until the next rising edge. That edge sets it to 0 even if a load or a count is requested.
- R4: With `clr_n` high and `ld_n` low, the next rising edge copies `din` into `digit`, whatever the values of `en_side` and `en_chain`.
- R5: With `clr_n` and `ld_n` high, if either `en_side` or `en_chain` is low, `digit` keeps its value across the edge.
- R6: `carry_out` is combinational. It is high exactly when `digit` is 9 (1001) and `en_chain` is high. `en_side` and `ld_n` do not affect it.
- R7: When counting, the codes above 9 step as follows: 10→11, 11→6, 12→13, 13→4, 14→15, 15→2. Each therefore reaches a decimal digit in at most two steps.
- R8: `carry_out` stays low for every code from 10 to 15, even when `en_chain` is high.
- R9: A loaded code from 10 to 15 stays unchanged while either count enable is low.
- R10: In a row of three stages, stage k's `carry_out` drives stage k+1's `en_chain`, and `en_side` and `ld_n` are shared. With the first stage's `en_chain` held high, the row counts 000 to 999 and then returns to 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous according to `ASYNC_CLR` |
| ld_n | input | 1 | Active-low preset request |
| din | input | 4 | Preset value |
| en_side | input | 1 | Count enable that does not affect the carry |
| en_chain | input | 1 | Count enable that also qualifies the carry |
| digit | output | 4 | Current digit, 8421 weighted |
| carry_out | output | 1 | High on digit 9 while `en_chain` is high |

## Verification
The stepping function is exercised in several ways:
- A free count across more than one full decade checks the step from 9 to 0.
- A preset request with both enables low, and another with both enables high, show that loading overrides counting.
- Lowering each enable by itself shows that either one alone stops the count.
- Each of the six codes above 9 is preset and then stepped twice. This separates the two kinds of code: even codes step to the next illegal code, odd codes jump straight back into the decimal range.

A clear issued between clock edges, while a load is requested, tells the two reset variants apart.

A three-digit row run for a full thousand steps checks that only the chain enable propagates the carry.

// File: rtl/bcd_stage_pkg.sv
package bcd_stage_pkg;

   localparam int unsigned DIGIT_W    = 4;
   localparam int unsigned LAST_DIGIT = 9;
   localparam int unsigned CODE_SPAN  = 1 << DIGIT_W;

   typedef logic [DIGIT_W-1:0] digit_t;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_LOAD  = 2'd2
   } stage_op_e;

   // Successor of a digit while counting.
   // Decimal digits advance with wrap after LAST_DIGIT.
   // Out-of-range even codes step to the next code.
   // Out-of-range odd codes fold back into range (value = CODE_SPAN+1-v).
   function automatic digit_t step_digit(input digit_t v);
      digit_t r;
      if (v == digit_t'(LAST_DIGIT))
         r = '0;
      else if (v < digit_t'(LAST_DIGIT))
         r = v + digit_t'(1);
      else if (v[0])
         r = digit_t'((DIGIT_W+1)'(CODE_SPAN + 1) - {1'b0, v});
      else
         r = v + digit_t'(1);
      return r;
   endfunction

endpackage

// File: rtl/bcd_op_select.sv
module bcd_op_select
   import bcd_stage_pkg::*;
(
   input  logic      ld_n,
   input  logic      en_side,
   input  logic      en_chain,
   output stage_op_e op
);

   always_comb begin
      if (!ld_n)
         op = OP_LOAD;
      else if (en_side && en_chain)
         op = OP_COUNT;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/bcd_next_value.sv
module bcd_next_value
   import bcd_stage_pkg::*;
(
   input  stage_op_e op,
   input  digit_t    cur,
   input  digit_t    din,
   output digit_t    nxt
);

   always_comb begin
      unique case (op)
         OP_LOAD:  nxt = din;
         OP_COUNT: nxt = step_digit(cur);
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/bcd_digit_reg.sv
module bcd_digit_reg
   import bcd_stage_pkg::*;
#(
   parameter int unsigned ASYNC_CLR = 1
)(
   input  logic   clk,
   input  logic   clr_n,
   input  digit_t nxt,
   output digit_t q
);

   generate
      if (ASYNC_CLR != 0) begin : g_async_clear
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n)
               q <= '0;
            else
               q <= nxt;
         end
      end else begin : g_sync_clear
         always_ff @(posedge clk) begin
            if (!clr_n)
               q <= '0;
            else
               q <= nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/bcd_carry_decode.sv
module bcd_carry_decode
   import bcd_stage_pkg::*;
(
   input  digit_t cur,
   input  logic   en_chain,
   output logic   carry
);

   localparam digit_t TOP_CODE = digit_t'(LAST_DIGIT);

   // Full decode of every bit so no out-of-range code can match.
   logic [DIGIT_W-1:0] bit_match;

   generate
      for (genvar b = 0; b < DIGIT_W; b++) begin : g_bit
         assign bit_match[b] = (cur[b] == TOP_CODE[b]);
      end
   endgenerate

   assign carry = en_chain && (&bit_match);

endmodule

// File: rtl/bcd_decade_stage.sv
module bcd_decade_stage
   import bcd_stage_pkg::*;
#(
   parameter int unsigned ASYNC_CLR = 1
)(
   input  logic                clk,
   input  logic                clr_n,
   input  logic                ld_n,
   input  logic [DIGIT_W-1:0]  din,
   input  logic                en_side,
   input  logic                en_chain,
   output logic [DIGIT_W-1:0]  digit,
   output logic                carry_out
);

   generate
      if (ASYNC_CLR > 1) begin : g_bad_clear_mode
         $error("bcd_decade_stage: ASYNC_CLR must be 0 or 1");
      end
      if (DIGIT_W != 4 || LAST_DIGIT != 9) begin : g_bad_code
         $error("bcd_decade_stage: decimal digit must be 4 bits wide");
      end
   endgenerate

   stage_op_e op;
   digit_t    cur;
   digit_t    nxt;

   bcd_op_select u_op (
      .ld_n     (ld_n),
      .en_side  (en_side),
      .en_chain (en_chain),
      .op       (op)
   );

   bcd_next_value u_next (
      .op  (op),
      .cur (cur),
      .din (din),
      .nxt (nxt)
   );

   bcd_digit_reg #(.ASYNC_CLR(ASYNC_CLR)) u_reg (
      .clk   (clk),
      .clr_n (clr_n),
      .nxt   (nxt),
      .q     (cur)
   );

   bcd_carry_decode u_carry (
      .cur      (cur),
      .en_chain (en_chain),
      .carry    (carry_out)
   );

   assign digit = cur;

endmodule

// File: rtl/bcd_stage_checker.sv
module bcd_stage_checker
   import bcd_stage_pkg::*;
#(
   parameter int unsigned ASYNC_CLR = 1
)(
   input logic               clk,
   input logic               clr_n,
   input logic               ld_n,
   input logic [DIGIT_W-1:0] din,
   input logic               en_side,
   input logic               en_chain,
   input logic [DIGIT_W-1:0] digit,
   input logic               carry_out
);

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   logic stepping;
   assign stepping = clr_n && ld_n && en_side && en_chain;

   p_wrap_r1: assert property (@(posedge clk) disable iff (!clr_n || !armed)
      (stepping && digit == 4'd9) |=> (digit == 4'd0));

   p_step_r1: assert property (@(posedge clk) disable iff (!clr_n || !armed)
      (stepping && digit < 4'd9) |=> (digit == $past(digit) + 4'd1));

   generate
      if (ASYNC_CLR != 0) begin : g_async_chk
         p_clear_now_r2: assert property (@(posedge clk) disable iff (!armed)
            (!clr_n) |-> (digit == 4'd0));
      end else begin : g_sync_chk
         p_clear_edge_r3: assert property (@(posedge clk) disable iff (!armed)
            (!clr_n) |=> (digit == 4'd0));
      end
   endgenerate

   p_load_r4: assert property (@(posedge clk) disable iff (!clr_n || !armed)
      (!ld_n) |=> (digit == $past(din)));

   p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n || !armed)
      (ld_n && !(en_side && en_chain)) |=> $stable(digit));

   p_carry_gate_r6: assert property (@(posedge clk) disable iff (!clr_n || !armed)
      (!en_chain) |-> (!carry_out));

   p_odd_fold_r7: assert property (@(posedge clk) disable iff (!clr_n || !armed)
      (stepping && digit > 4'd9 && digit[0]) |=> (digit <= 4'd9));

   p_even_climb_r7: assert property (@(posedge clk) disable iff (!clr_n || !armed)
      (stepping && digit > 4'd9 && !digit[0]) |=> (digit == $past(digit) + 4'd1));

   p_carry_legal_r8: assert property (@(posedge clk) disable iff (!clr_n || !armed)
      carry_out |-> (digit == 4'd9));

endmodule

bind bcd_decade_stage bcd_stage_checker #(.ASYNC_CLR(ASYNC_CLR)) u_stage_chk (
   .clk       (clk),
   .clr_n     (clr_n),
   .ld_n      (ld_n),
   .din       (din),
   .en_side   (en_side),
   .en_chain  (en_chain),
   .digit     (digit),
   .carry_out (carry_out)
);

// File: tb/test_bcd_decade_stage.sv
`timescale 1ns/1ps
module test_bcd_decade_stage;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   int total = 0;
   int bad   = 0;
   logic finished = 1'b0;

   // Shared stimulus for the single-stage instances.
   logic       clr_n;
   logic       ld_n;
   logic [3:0] din;
   logic       en_side;
   logic       en_chain;
   logic [3:0] dig_a, dig_s;
   logic       cy_a, cy_s;

   bcd_decade_stage #(.ASYNC_CLR(1)) i_bcd_decade_stage (
      .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
      .en_side(en_side), .en_chain(en_chain),
      .digit(dig_a), .carry_out(cy_a)
   );

   bcd_decade_stage #(.ASYNC_CLR(0)) i_bcd_decade_stage_sync (
      .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
      .en_side(en_side), .en_chain(en_chain),
      .digit(dig_s), .carry_out(cy_s)
   );

   // Three-digit row for R10.
   logic       row_clr_n, row_ld_n, row_side, row_first;
   logic [3:0] row_dig [3];
   logic       row_cy  [3];

   bcd_decade_stage u_row0 (
      .clk(clk), .clr_n(row_clr_n), .ld_n(row_ld_n), .din(4'd0),
      .en_side(row_side), .en_chain(row_first),
      .digit(row_dig[0]), .carry_out(row_cy[0])
   );
   bcd_decade_stage u_row1 (
      .clk(clk), .clr_n(row_clr_n), .ld_n(row_ld_n), .din(4'd0),
      .en_side(row_side), .en_chain(row_cy[0]),
      .digit(row_dig[1]), .carry_out(row_cy[1])
   );
   bcd_decade_stage u_row2 (
      .clk(clk), .clr_n(row_clr_n), .ld_n(row_ld_n), .din(4'd0),
      .en_side(row_side), .en_chain(row_cy[1]),
      .digit(row_dig[2]), .carry_out(row_cy[2])
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // From one falling edge to the next, crossing one rising edge.
   task automatic tick();
      @(negedge clk);
   endtask

   function automatic int odd_map(input int v);
      int r;
      case (v)
         10: r = 11;  11: r = 6;
         12: r = 13;  13: r = 4;
         14: r = 15;  15: r = 2;
         default: r = (v == 9) ? 0 : v + 1;
      endcase
      return r;
   endfunction

   task automatic preset(input int v);
      ld_n = 1'b0; din = 4'(v);
      tick();
      ld_n = 1'b1;
   endtask

   task automatic t_reset();
      clr_n = 1'b0; ld_n = 1'b1; din = 4'd0; en_side = 1'b0; en_chain = 1'b0;
      tick(); tick();
      chk("R2 reset state async", dig_a, 0);
      chk("R3 reset state sync", dig_s, 0);
      clr_n = 1'b1;
      preset(7);
      chk("R4 preset before clear async", dig_a, 7);
      chk("R4 preset before clear sync", dig_s, 7);
      // Clear between edges while a load and a count are requested.
      ld_n = 1'b0; din = 4'd5; en_side = 1'b1; en_chain = 1'b1;
      #2 clr_n = 1'b0;
      #1;
      chk("R2 async clear without clock", dig_a, 0);
      chk("R3 sync clear waits for edge", dig_s, 7);
      tick();
      chk("R3 sync clear overrides load", dig_s, 0);
      chk("R2 async stays clear", dig_a, 0);
      clr_n = 1'b1; ld_n = 1'b1; en_side = 1'b0; en_chain = 1'b0;
      tick();
   endtask

   task automatic t_count();
      en_side = 1'b1; en_chain = 1'b1;
      for (int i = 1; i <= 12; i++) begin
         tick();
         chk("R1 count step async", dig_a, i % 10);
         chk("R1 count step sync", dig_s, i % 10);
      end
      en_side = 1'b0; en_chain = 1'b0;
   endtask

   task automatic t_load();
      en_side = 1'b0; en_chain = 1'b0;
      preset(3);
      chk("R4 load with enables low", dig_a, 3);
      en_side = 1'b1; en_chain = 1'b1;
      preset(8);
      chk("R4 load beats count", dig_a, 8);
      chk("R4 load beats count sync", dig_s, 8);
      en_side = 1'b0; en_chain = 1'b0;
   endtask

   task automatic t_hold();
      preset(4);
      en_side = 1'b0; en_chain = 1'b1;
      tick();
      chk("R5 hold side enable low", dig_a, 4);
      en_side = 1'b1; en_chain = 1'b0;
      tick();
      chk("R5 hold chain enable low", dig_a, 4);
      en_side = 1'b0; en_chain = 1'b0;
      tick();
      chk("R5 hold both low", dig_s, 4);
   endtask

   task automatic t_carry();
      preset(9);
      en_side = 1'b0; en_chain = 1'b1;
      #1 chk("R6 carry at nine, side low", cy_a, 1);
      ld_n = 1'b0; din = 4'd2;
      #1 chk("R6 carry unaffected by load request", cy_a, 1);
      en_chain = 1'b0;
      #1 chk("R6 carry gated by chain enable", cy_a, 0);
      ld_n = 1'b1;
      preset(8);
      en_chain = 1'b1;
      #1 chk("R6 carry low at eight", cy_a, 0);
      en_chain = 1'b0;
      tick();
   endtask

   task automatic t_illegal();
      for (int v = 10; v <= 15; v++) begin
         en_side = 1'b0; en_chain = 1'b0;
         preset(v);
         en_chain = 1'b1;
         tick();
         chk("R9 illegal code held", dig_a, v);
         chk("R9 illegal code held sync", dig_s, v);
         chk("R8 no carry on illegal code", cy_a, 0);
         en_side = 1'b1;
         tick();
         chk("R7 first step from illegal", dig_a, odd_map(v));
         tick();
         chk("R7 second step is legal", dig_a, odd_map(odd_map(v)));
         chk("R7 legal within two steps", (dig_s <= 4'd9) ? 1 : 0, 1);
      end
      en_side = 1'b0; en_chain = 1'b0;
   endtask

   task automatic t_row();
      row_clr_n = 1'b0; row_ld_n = 1'b1; row_side = 1'b0; row_first = 1'b0;
      tick(); tick();
      row_clr_n = 1'b1; row_side = 1'b1; row_first = 1'b1;
      chk("R10 row cleared", row_dig[2]*100 + row_dig[1]*10 + row_dig[0], 0);
      for (int n = 1; n <= 1002; n++) begin
         tick();
         chk("R10 row value", row_dig[2]*100 + row_dig[1]*10 + row_dig[0], n % 1000);
         if (n == 999) chk("R10 top carry at 999", row_cy[2], 1);
      end
      row_side = 1'b0;
   endtask

   initial begin
      row_clr_n = 1'b0; row_ld_n = 1'b1; row_side = 1'b0; row_first = 1'b0;
      @(negedge clk);
      t_reset();
      t_count();
      t_load();
      t_hold();
      t_carry();
      t_illegal();
      t_row();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule